// File: doc/BRIEF.md
# Infrared Remote Carrier and Envelope Modulator

This block builds the drive signal for an infrared remote-control emitter. A carrier generator makes a square wave whose high and low phases are set separately, each counted in ticks of a prescaled carrier clock. An envelope timer counts ticks of a second prescaled clock. It times how long the current output level lasts, and it uses a separate width for a high level and for a low level. At the end of each interval the timer loads the next level that software has staged, and it raises an interrupt so that software can stage the level after that.

Software reaches the block through a simple write port: an address, a data word and a write strobe. A mode bit selects whether the pin carries the carrier gated by the envelope level or the bare envelope level. Widths written while a phase or interval runs are held back until that phase or interval ends, so the pin never shows a shortened or stretched pulse. The pin is registered and follows its inputs by one clock.

Top module: `ir_modulator`

## Requirements
- R1: While the carrier enable is set, the carrier high phase lasts as many carrier ticks as the carrier-high register holds and the low phase as many as the carrier-low register holds. A width of 0 means 256 ticks. While the enable is clear the carrier is low, and it restarts with a full high phase when enabled.
- R2: While the envelope enable is set, each envelope interval lasts width+1 envelope ticks. The width is the envelope-high register while the level is 1 and the envelope-low register while the level is 0.
- R3: At the end of an interval the envelope counter restarts and the level takes the value of the next-level register.
- R4: The interrupt flag is set at the end of every interval while the envelope enable is set, and it is never set while the envelope enable is clear.
- R5: A pulse on `irq_ack` clears the interrupt flag. A new interval end in the same cycle keeps the flag set.
- R6: A write to the level register changes the level at once and starts a fresh interval that uses the width matching the new level.
- R7: With the raw-mode bit 0 the pin is level AND carrier; with the raw-mode bit 1 the pin is the level. The pin is 0 whenever both enables are clear. The pin is registered, one clock after its inputs.
- R8: Reset sets both carrier widths to 0xFF and both envelope widths to 0xFFFF. It clears all control bits, the level, the next level, the interrupt flag and the pin.
- R9: A width written during a carrier phase or envelope interval takes effect only from the next phase or interval.
- R10: Write map: address 0 control (bit 0 carrier enable, bit 1 envelope enable, bit 2 raw mode), 1 carrier high, 2 carrier low, 3 envelope high, 4 envelope low, 5 level (bit 0), 6 next level (bit 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| car_tick | input | 1 | Prescaled carrier clock enable |
| env_tick | input | 1 | Prescaled envelope clock enable |
| irq_ack | input | 1 | Interrupt serviced, clears the flag |
| ir_out | output | 1 | Modulated emitter drive |
| irq | output | 1 | Interval-end interrupt flag |

## Verification
A wrong carrier count or a shadow width taken at the wrong moment shows up as a high or low run on the pin of the wrong length. The bench sees this within one carrier period, because it measures whole runs after a fresh enable and after a mid-phase write. A wrong compare choice or a bad level reload in the envelope timer gives a wrong high-run length or a wrong interrupt spacing within one interval. Interrupt gating and acknowledge errors show up on `irq` one sample after the acknowledge, or during a quiet window with the envelope disabled.

// File: rtl/ir_mod_pkg.sv
package ir_mod_pkg;
    localparam int CAR_W  = 8;
    localparam int DAT_W  = 16;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 3'd0,
        REG_CAR_HI = 3'd1,
        REG_CAR_LO = 3'd2,
        REG_ENV_HI = 3'd3,
        REG_ENV_LO = 3'd4,
        REG_LEVEL  = 3'd5,
        REG_NEXT   = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic             car_en;
        logic             env_en;
        logic             raw_mode;
        logic             next_lvl;
        logic [CAR_W-1:0] car_hi;
        logic [CAR_W-1:0] car_lo;
        logic [DAT_W-1:0] env_hi;
        logic [DAT_W-1:0] env_lo;
    } mod_cfg_t;

    function automatic logic mix_pin(input logic carrier, input logic level,
                                     input logic raw_mode, input logic car_en,
                                     input logic env_en);
        if (!car_en && !env_en) return 1'b0;
        return raw_mode ? level : (level & carrier);
    endfunction
endpackage

// File: rtl/ir_mod_regs.sv
module ir_mod_regs
    import ir_mod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DAT_W-1:0]  wr_data,
    output mod_cfg_t          cfg,
    output logic              lvl_wr,
    output logic              lvl_val
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.car_en   <= 1'b0;
            cfg.env_en   <= 1'b0;
            cfg.raw_mode <= 1'b0;
            cfg.next_lvl <= 1'b0;
            cfg.car_hi   <= '1;
            cfg.car_lo   <= '1;
            cfg.env_hi   <= '1;
            cfg.env_lo   <= '1;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_CTRL: begin
                    cfg.car_en   <= wr_data[0];
                    cfg.env_en   <= wr_data[1];
                    cfg.raw_mode <= wr_data[2];
                end
                REG_CAR_HI: cfg.car_hi   <= wr_data[CAR_W-1:0];
                REG_CAR_LO: cfg.car_lo   <= wr_data[CAR_W-1:0];
                REG_ENV_HI: cfg.env_hi   <= wr_data;
                REG_ENV_LO: cfg.env_lo   <= wr_data;
                REG_NEXT:   cfg.next_lvl <= wr_data[0];
                default: ;
            endcase
        end
    end

    assign lvl_wr  = wr_en && (reg_addr_e'(wr_addr) == REG_LEVEL);
    assign lvl_val = wr_data[0];
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
    import ir_mod_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [CAR_W-1:0] hi_w,
    input  logic [CAR_W-1:0] lo_w,
    output logic             carrier
);
    logic             phase;
    logic [CAR_W-1:0] cnt;
    logic [CAR_W-1:0] sh_hi;
    logic [CAR_W-1:0] sh_lo;
    logic [CAR_W-1:0] cur_w;
    logic             last;

    assign cur_w = phase ? sh_hi : sh_lo;
    assign last  = (cnt == cur_w - CAR_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase <= 1'b1;
            cnt   <= '0;
            sh_hi <= hi_w;
            sh_lo <= lo_w;
        end else if (tick) begin
            if (last) begin
                phase <= ~phase;
                cnt   <= '0;
                sh_hi <= hi_w;
                sh_lo <= lo_w;
            end else begin
                cnt <= cnt + CAR_W'(1);
            end
        end
    end

    assign carrier = en & phase;

    a_r1_cnt_in_phase: assert property (@(posedge clk) disable iff (rst)
        (cur_w != '0) |-> (cnt < cur_w));
    a_r1_phase_needs_tick: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(phase));
endmodule

// File: rtl/ir_envelope_timer.sv
module ir_envelope_timer
    import ir_mod_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [DAT_W-1:0] hi_w,
    input  logic [DAT_W-1:0] lo_w,
    input  logic             next_lvl,
    input  logic             lvl_wr,
    input  logic             lvl_val,
    input  logic             irq_ack,
    output logic             level,
    output logic             irq
);
    logic [DAT_W-1:0] cnt;
    logic [DAT_W-1:0] cmp;
    logic             match;

    assign match = en && tick && !lvl_wr && (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b0;
            cnt   <= '0;
            cmp   <= '1;
        end else if (lvl_wr) begin
            level <= lvl_val;
            cnt   <= '0;
            cmp   <= lvl_val ? hi_w : lo_w;
        end else if (!en) begin
            cnt <= '0;
            cmp <= level ? hi_w : lo_w;
        end else if (tick) begin
            if (cnt == cmp) begin
                level <= next_lvl;
                cnt   <= '0;
                cmp   <= next_lvl ? hi_w : lo_w;
            end else begin
                cnt <= cnt + DAT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          irq <= 1'b0;
        else if (match)   irq <= 1'b1;
        else if (irq_ack) irq <= 1'b0;
    end

    a_r2_cnt_within_cmp: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt <= cmp));
    a_r4_no_irq_when_off: assert property (@(posedge clk) disable iff (rst)
        (!irq && !en) |=> !irq);
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !match) |=> !irq);
    a_r6_level_write: assert property (@(posedge clk) disable iff (rst)
        lvl_wr |=> (level == $past(lvl_val)) && (cnt == '0));
endmodule

// File: rtl/ir_modulator.sv
module ir_modulator
    import ir_mod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DAT_W-1:0]  wr_data,
    input  logic              car_tick,
    input  logic              env_tick,
    input  logic              irq_ack,
    output logic              ir_out,
    output logic              irq
);
    mod_cfg_t cfg;
    logic     lvl_wr;
    logic     lvl_val;
    logic     carrier;
    logic     level;

    ir_mod_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg(cfg), .lvl_wr(lvl_wr), .lvl_val(lvl_val)
    );

    ir_carrier_gen u_car (
        .clk(clk), .rst(rst), .en(cfg.car_en), .tick(car_tick),
        .hi_w(cfg.car_hi), .lo_w(cfg.car_lo), .carrier(carrier)
    );

    ir_envelope_timer u_env (
        .clk(clk), .rst(rst), .en(cfg.env_en), .tick(env_tick),
        .hi_w(cfg.env_hi), .lo_w(cfg.env_lo), .next_lvl(cfg.next_lvl),
        .lvl_wr(lvl_wr), .lvl_val(lvl_val), .irq_ack(irq_ack),
        .level(level), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) ir_out <= 1'b0;
        else     ir_out <= mix_pin(carrier, level, cfg.raw_mode, cfg.car_en, cfg.env_en);
    end

    a_r7_low_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!cfg.car_en && !cfg.env_en) |=> !ir_out);
    a_r7_gated_by_level: assert property (@(posedge clk) disable iff (rst)
        !level |=> !ir_out);
endmodule

// File: tb/ir_modulator_tb.sv
`timescale 1ns/1ps
module ir_modulator_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        car_tick = 1'b0;
    logic        env_tick = 1'b0;
    logic        irq_ack = 1'b0;
    logic        ir_out;
    logic        irq;
    logic        car_div = 1'b0;
    int          n_checks = 0;
    int          n_errors = 0;

    always #2.5 clk = ~clk;

    always @(negedge clk) car_tick <= car_div ? ~car_tick : 1'b1;

    ir_modulator u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .car_tick(car_tick), .env_tick(env_tick), .irq_ack(irq_ack),
        .ir_out(ir_out), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_len(input logic v, input int lim, output int n);
        int w = 0;
        while (ir_out !== v && w < lim) begin @(negedge clk); w++; end
        n = 0;
        while (ir_out === v && n < lim) begin @(negedge clk); n++; end
    endtask

    task automatic do_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state;
        chk("R8 pin after reset", ir_out, 0);
        chk("R8 irq after reset", irq, 0);
    endtask

    task automatic t_carrier_reset_widths;
        int h, l;
        wr(3'd5, 16'd1);
        wr(3'd0, 16'h1);
        run_len(1'b1, 1000, h);
        run_len(1'b0, 1000, l);
        chk("R8 R1 default carrier high run", h, 255);
        chk("R8 R1 default carrier low run", l, 255);
    endtask

    task automatic t_carrier_ratio;
        int h, l;
        wr(3'd0, 16'h0);
        wr(3'd1, 16'd3);
        wr(3'd2, 16'd5);
        wr(3'd0, 16'h1);
        run_len(1'b1, 1000, h); run_len(1'b0, 1000, l); run_len(1'b1, 1000, h);
        chk("R1 carrier high 3 ticks", h, 3);
        chk("R1 carrier low 5 ticks", l, 5);
        wr(3'd0, 16'h0);
        car_div = 1'b1;
        wr(3'd0, 16'h1);
        run_len(1'b1, 1000, h); run_len(1'b0, 1000, l); run_len(1'b1, 1000, h);
        chk("R1 half-rate carrier high", h, 6);
        chk("R1 half-rate carrier low", l, 10);
        car_div = 1'b0;
        wr(3'd0, 16'h0);
        wr(3'd1, 16'd0);
        wr(3'd2, 16'd1);
        wr(3'd0, 16'h1);
        run_len(1'b1, 1000, h);
        chk("R1 zero width means 256", h, 256);
    endtask

    task automatic t_glitch_free;
        int n, l, h;
        wr(3'd0, 16'h0);
        wr(3'd1, 16'd3);
        wr(3'd2, 16'd4);
        wr(3'd0, 16'h1);
        while (ir_out !== 1'b1) @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'd6;
        n = 1;
        @(negedge clk);
        wr_en = 1'b0;
        while (ir_out === 1'b1 && n < 100) begin n++; @(negedge clk); end
        chk("R9 running high phase keeps old width", n, 3);
        run_len(1'b0, 100, l);
        run_len(1'b1, 100, h);
        chk("R9 low phase unchanged", l, 4);
        chk("R9 new width on next high phase", h, 6);
    endtask

    task automatic t_mode_mix;
        int ones = 0;
        wr(3'd0, 16'h0);
        wr(3'd5, 16'd1);
        repeat (3) @(negedge clk);
        chk("R7 pin low with both enables off", ir_out, 0);
        wr(3'd0, 16'h4);
        repeat (3) @(negedge clk);
        chk("R7 raw mode still low with both enables off", ir_out, 0);
        wr(3'd0, 16'h5);
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin ones += int'(ir_out); @(negedge clk); end
        chk("R7 raw mode passes level", ones, 10);
    endtask

    task automatic t_env_high;
        int h;
        wr(3'd0, 16'h0);
        wr(3'd5, 16'd0);
        wr(3'd3, 16'd4);
        wr(3'd4, 16'd2);
        wr(3'd6, 16'd0);
        env_tick = 1'b1;
        wr(3'd0, 16'h6);
        repeat (4) @(negedge clk);
        chk("R7 raw pin low at level 0", ir_out, 0);
        wr(3'd5, 16'd1);
        run_len(1'b1, 1000, h);
        chk("R2 R3 R6 high interval is high width + 1", h, 5);
    endtask

    task automatic t_irq;
        int n;
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        while (irq !== 1'b1) @(negedge clk);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk("R5 ack clears irq", irq, 0);
        n = 1;
        while (irq !== 1'b1 && n < 100) begin @(negedge clk); n++; end
        chk("R4 R2 irq spacing at level 0 is low width + 1", n, 3);
    endtask

    task automatic t_next_level;
        int ones = 0;
        wr(3'd6, 16'd1);
        repeat (6) @(negedge clk);
        for (int i = 0; i < 10; i++) begin ones += int'(ir_out); @(negedge clk); end
        chk("R3 next level 1 loaded and held", ones, 10);
    endtask

    task automatic t_irq_gate;
        int seen = 0;
        wr(3'd0, 16'h4);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        for (int i = 0; i < 20; i++) begin seen += int'(irq); @(negedge clk); end
        chk("R4 no irq with envelope disabled", seen, 0);
    endtask

    task automatic t_env_reset_widths;
        int h;
        do_reset;
        chk("R8 pin after second reset", ir_out, 0);
        chk("R8 irq after second reset", irq, 0);
        wr(3'd0, 16'h6);
        wr(3'd5, 16'd1);
        run_len(1'b1, 70000, h);
        chk("R8 R10 default envelope high interval", h, 65536);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        do_reset;
        t_reset_state;
        t_carrier_reset_widths;
        t_carrier_ratio;
        t_glitch_free;
        t_mode_mix;
        t_env_high;
        t_irq;
        t_next_level;
        t_irq_gate;
        t_env_reset_widths;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule